// File: doc/BRIEF.md
# Triple Comparator Control and Event Logic

This block is the digital side of a group of three analog comparators. A small word-addressed register bus holds one control word per comparator, a status word and a shared reference control word. The control fields are driven straight out to the analog macro (power enable, positive and negative input selection, hysteresis) along with the reference level and source settings.

The three raw comparator results come in asynchronously. Each one is synchronised, optionally inverted and reported in the status word. A reported value stays forced low for a programmable number of clock cycles after the comparator is switched on, which covers the analog settling time. Once the result has settled, any change of the reported value latches a sticky per-comparator flag. Software clears a flag by writing 1 to it. A single interrupt line is raised while any flag is set whose comparator has its interrupt enable on.

Top module: `tricmp_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and all analog control outputs are 0.
- R2: The comparator control words sit at byte offsets 0x0, 0x4 and 0x8. Their fields are: bit0 power enable, bit1 interrupt enable, bit2 hysteresis, bit3 output invert, bit4 negative input (1 = internal reference), bits7:5 positive input code. The word reads back with bits 31:8 as 0, and its fields drive `cmp_en`, `cmp_hyst`, `cmp_neg_int` and `cmp_pos_sel[3i+2:3i]`.
- R3: A positive input code above 4 for comparators 0 and 1, or above 3 for comparator 2, is reserved. A write carrying a reserved code leaves the stored code unchanged and still updates the other fields of the word.
- R4: The reference word at 0x10 holds the level in bits3:0, the source select in bit6 and the internal-reference select in bit7. Bits 5:4 and 31:8 read 0. The fields drive `ref_level`, `ref_src_int` and `ref_div_sel`.
- R5: The reported output of a comparator (status bit 3+i) reads 0 while the comparator is disabled. After its enable goes from 0 to 1 it also reads 0 for SETTLE_CYC clock edges, and on the edge after that it shows the live value.
- R6: Once settled, the reported output equals the raw input XOR the invert bit. A raw change becomes visible in the status word two clock edges after it is applied.
- R7: A flag (status bit i) is set on the edge after the settled reported output changes. No flag is set when the output first becomes valid, and none is set while the comparator is disabled.
- R8: Writing 1 to a flag bit at 0xC clears it, and writing 0 leaves it unchanged.
- R9: If a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when some comparator has both its flag and its interrupt enable set. A flag is latched whatever its interrupt enable is.
- R11: Writes to status bits 5:3 have no effect. Offsets 0x14, 0x18 and 0x1C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cmp_raw | input | 3 | Raw comparator results, asynchronous |
| cmp_en | output | 3 | Comparator power enables |
| cmp_hyst | output | 3 | Hysteresis enables |
| cmp_neg_int | output | 3 | Negative input uses internal reference |
| cmp_pos_sel | output | 9 | Positive input codes, 3 bits per comparator |
| ref_level | output | 4 | Reference ladder level |
| ref_src_int | output | 1 | Reference ladder fed from internal reference |
| ref_div_sel | output | 1 | Internal reference taken from divided ladder |
| irq | output | 1 | Combined interrupt request |

## Verification
If the settle counter is wrong, the reported output bit shows the raw value too early or too late. The bench sees this on the exact edge, because it samples the status word every cycle through the whole settle window. A wrong synchroniser depth or a lost previous-value register shows up two to three edges after a raw toggle, as a status bit or flag that differs from the arithmetic expectation. A corrupted flag or enable shows on `irq` in the cycle after the offending write, and this is swept over all flag and enable combinations.

// File: rtl/tricmp_pkg.sv
`timescale 1ns/1ps
package tricmp_pkg;
   localparam int NCMP     = 3;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 32;
   localparam int CTL_W    = 8;
   localparam int POSSEL_W = 3;

   // word index = byte address / 4
   localparam logic [2:0] IDX_STAT = 3'd3;
   localparam logic [2:0] IDX_REF  = 3'd4;

   // bit 0 is the last member
   typedef struct packed {
      logic [POSSEL_W-1:0] pos;
      logic                neg_int;
      logic                inv;
      logic                hyst;
      logic                ie;
      logic                en;
   } cmp_ctl_t;

   typedef struct packed {
      logic       div_sel;
      logic       src_int;
      logic [1:0] zero;
      logic [3:0] level;
   } ref_ctl_t;

   // highest legal positive input code per comparator
   function automatic int pos_code_max(int idx);
      return (idx == 2) ? 3 : 4;
   endfunction
endpackage

// File: rtl/tricmp_sync.sv
`timescale 1ns/1ps
module tricmp_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("tricmp_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/tricmp_ref.sv
`timescale 1ns/1ps
module tricmp_ref
   import tricmp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output ref_ctl_t         rc
);
   ref_ctl_t rc_q;
   logic     unused_rsvd;

   assign unused_rsvd = ^wdata[5:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rc_q <= '0;
      else if (we) begin
         rc_q.level   <= wdata[3:0];
         rc_q.zero    <= 2'b00;
         rc_q.src_int <= wdata[6];
         rc_q.div_sel <= wdata[7];
      end
   end

   assign rc = rc_q;

   // R4
   ref_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rc_q.level == $past(wdata[3:0]) && rc_q.div_sel == $past(wdata[7])));
endmodule

// File: rtl/tricmp_chan.sv
`timescale 1ns/1ps
module tricmp_chan
   import tricmp_pkg::*;
#(
   parameter int SETTLE_CYC  = 400,
   parameter int POS_MAX     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             flag_clr,
   input  logic             raw,
   output cmp_ctl_t         ctl,
   output logic             rpt,
   output logic             flag
);
   cmp_ctl_t ctl_q, wr_val;
   logic     raw_s, ready, ready_q, rpt_q, chg, flag_q;

   if (POS_MAX < 0 || POS_MAX > (1 << POSSEL_W) - 1) begin : g_bad_posmax
      $error("tricmp_chan: POS_MAX out of range");
   end
   if (SETTLE_CYC < 0) begin : g_bad_settle
      $error("tricmp_chan: SETTLE_CYC must not be negative");
   end

   // reserved positive codes keep the stored code
   always_comb begin
      wr_val = cmp_ctl_t'(ctl_wdata);
      if (int'(wr_val.pos) > POS_MAX) wr_val.pos = ctl_q.pos;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= wr_val;
   end

   tricmp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (raw_s)
   );

   if (SETTLE_CYC == 0) begin : g_nosettle
      assign ready = ctl_q.en;
   end else begin : g_settle
      localparam int CNT_W = $clog2(SETTLE_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= CNT_LOAD;
         else if (!ctl_q.en)    cnt <= CNT_LOAD;
         else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
      end
      assign ready = ctl_q.en && (cnt == '0);

      // R5
      settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ctl_q.en) |-> !rpt);
   end

   assign rpt = ready & (raw_s ^ ctl_q.inv);
   assign chg = ready & ready_q & (rpt ^ rpt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rpt_q   <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         ready_q <= ready;
         rpt_q   <= rpt;
         flag_q  <= chg | (flag_q & ~flag_clr);
      end
   end

   assign ctl  = ctl_q;
   assign flag = flag_q;

   // R3
   pos_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && int'(ctl_wdata[7:5]) > POS_MAX) |=> ctl_q.pos == $past(ctl_q.pos));
   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && rpt != $past(rpt)) |=> flag_q);
   // R8
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !chg) |=> !flag_q);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && chg) |=> flag_q);
   // R5
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.en |-> !rpt);
endmodule

// File: rtl/tricmp_ctrl.sv
`timescale 1ns/1ps
module tricmp_ctrl
   import tricmp_pkg::*;
#(
   parameter int SETTLE_CYC  = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [2:0]        cmp_raw,
   output logic [2:0]        cmp_en,
   output logic [2:0]        cmp_hyst,
   output logic [2:0]        cmp_neg_int,
   output logic [8:0]        cmp_pos_sel,
   output logic [3:0]        ref_level,
   output logic              ref_src_int,
   output logic              ref_div_sel,
   output logic              irq
);
   localparam int STAT_OUT_LSB = NCMP;

   logic [2:0]      widx;
   logic [NCMP-1:0] flag_v, rpt_v, ie_v, clr_v;
   cmp_ctl_t        ctl_v [NCMP];
   ref_ctl_t        rc;
   logic            unused_bus;

   assign widx       = bus_addr[4:2];
   assign unused_bus = ^{bus_addr[1:0], bus_wdata[31:CTL_W]};
   assign clr_v      = (bus_we && widx == IDX_STAT) ? bus_wdata[NCMP-1:0] : '0;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      tricmp_chan #(
         .SETTLE_CYC (SETTLE_CYC),
         .POS_MAX    (pos_code_max(i)),
         .SYNC_STAGES(SYNC_STAGES)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_we   (bus_we && widx == 3'(i)),
         .ctl_wdata(bus_wdata[CTL_W-1:0]),
         .flag_clr (clr_v[i]),
         .raw      (cmp_raw[i]),
         .ctl      (ctl_v[i]),
         .rpt      (rpt_v[i]),
         .flag     (flag_v[i])
      );
      assign cmp_en[i]                           = ctl_v[i].en;
      assign cmp_hyst[i]                         = ctl_v[i].hyst;
      assign cmp_neg_int[i]                      = ctl_v[i].neg_int;
      assign cmp_pos_sel[POSSEL_W*i +: POSSEL_W] = ctl_v[i].pos;
      assign ie_v[i]                             = ctl_v[i].ie;
   end

   tricmp_ref u_ref (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bus_we && widx == IDX_REF),
      .wdata(bus_wdata[CTL_W-1:0]),
      .rc   (rc)
   );

   assign ref_level   = rc.level;
   assign ref_src_int = rc.src_int;
   assign ref_div_sel = rc.div_sel;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCMP; i++) begin
         if (widx == 3'(i)) bus_rdata[CTL_W-1:0] = ctl_v[i];
      end
      if (widx == IDX_STAT) begin
         bus_rdata[NCMP-1:0]                 = flag_v;
         bus_rdata[STAT_OUT_LSB +: NCMP]     = rpt_v;
      end
      if (widx == IDX_REF) bus_rdata[CTL_W-1:0] = rc;
   end

   assign irq = |(flag_v & ie_v);

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v == '0 || ie_v == '0) |-> !irq);
   // R11
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (widx > IDX_REF) |-> bus_rdata == '0);
endmodule

// File: tb/tricmp_ctrl_bench.sv
`timescale 1ns/1ps
module tricmp_ctrl_bench;
   localparam int S = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  cmp_raw = '0;
   logic [2:0]  cmp_en, cmp_hyst, cmp_neg_int;
   logic [8:0]  cmp_pos_sel;
   logic [3:0]  ref_level;
   logic        ref_src_int, ref_div_sel, irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   tricmp_ctrl #(.SETTLE_CYC(S), .SYNC_STAGES(2)) u_tricmp_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
      .cmp_en(cmp_en), .cmp_hyst(cmp_hyst), .cmp_neg_int(cmp_neg_int),
      .cmp_pos_sel(cmp_pos_sel), .ref_level(ref_level),
      .ref_src_int(ref_src_int), .ref_div_sel(ref_div_sel), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_raw(input logic [2:0] v);
      @(negedge clk);
      cmp_raw = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [2:0]  exp_pos [3];
      logic [2:0]  rawv;
      logic [2:0]  stat_out;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), d);
         chk("R1 reg after reset", d, 32'h0);
      end
      chk("R1 outputs after reset",
          {cmp_en, cmp_hyst, cmp_neg_int, cmp_pos_sel, ref_level, ref_src_int, ref_div_sel, irq},
          '0);

      // R2 R3 sweep of every positive code on each comparator
      for (int ch = 0; ch < 3; ch++) begin
         exp_pos[ch] = 3'd0;
         for (int code = 0; code < 8; code++) begin
            logic [4:0] lo;
            int         pmax;
            pmax = (ch == 2) ? 3 : 4;
            lo = 5'((code * 5 + ch) & 5'h1E);
            wr(5'(ch * 4), 32'hFFFF_FF00 | (32'(code) << 5) | 32'(lo));
            if (code <= pmax) exp_pos[ch] = 3'(code);
            rd(5'(ch * 4), d);
            chk("R3 stored positive code", d, {24'h0, exp_pos[ch], lo});
            chk("R2 pos port", 32'(cmp_pos_sel[ch*3 +: 3]), 32'(exp_pos[ch]));
            chk("R2 field ports", {29'h0, cmp_hyst[ch], cmp_neg_int[ch], cmp_en[ch]},
                {29'h0, lo[2], lo[4], lo[0]});
         end
         wr(5'(ch * 4), 32'h0);
      end

      // R4 reference word
      for (int k = 0; k < 5; k++) begin
         logic [31:0] v;
         v = (k == 4) ? 32'hFFFF_FFFF : 32'(8'hFF >> k) ^ (32'h5A << k);
         wr(5'h10, v);
         rd(5'h10, d);
         chk("R4 ref readback", d, v & 32'hCF);
         chk("R4 ref ports", {26'h0, ref_div_sel, ref_src_int, ref_level},
             {26'h0, v[7], v[6], v[3:0]});
      end

      // R11 unmapped offsets
      for (int a = 5; a < 8; a++) begin
         wr(5'(a * 4), 32'hFFFF_FFFF);
         rd(5'(a * 4), d);
         chk("R11 unmapped reads 0", d, 32'h0);
      end
      for (int a = 0; a < 4; a++) begin
         rd(5'(a * 4), d);
         chk("R11 unmapped write left regs", d, 32'h0);
      end
      rd(5'h10, d);
      chk("R11 unmapped write left ref", d, 32'hCF);

      // R5 settle window, R7 no flag at settle
      cmp_raw = 3'b111;
      repeat (3) @(negedge clk);
      for (int ch = 0; ch < 3; ch++) begin
         wr(5'(ch * 4), 32'h1);
         bus_addr = 5'h0C;
         for (int j = 0; j <= S; j++) begin
            if (j > 0) @(negedge clk);
            #1;
            chk("R5 settle output", 32'(bus_rdata[3 + ch]), (j == S) ? 32'h1 : 32'h0);
            chk("R7 no flag during settle", 32'(bus_rdata[ch]), 32'h0);
         end
         @(negedge clk); #1;
         chk("R7 no flag on becoming valid", 32'(bus_rdata[ch]), 32'h0);
      end
      rd(5'h0C, d);
      chk("R5 all settled", d, 32'h38);

      // R6 latency, R7 flag timing
      for (int ch = 0; ch < 3; ch++) begin
         @(negedge clk);
         cmp_raw[ch] = 1'b0;
         bus_addr = 5'h0C;
         #1 chk("R6 before first edge", 32'(bus_rdata[3 + ch]), 32'h1);
         @(negedge clk); #1;
         chk("R6 after one edge", 32'(bus_rdata[3 + ch]), 32'h1);
         @(negedge clk); #1;
         chk("R6 after two edges", 32'(bus_rdata[3 + ch]), 32'h0);
         chk("R7 flag not yet", 32'(bus_rdata[ch]), 32'h0);
         @(negedge clk); #1;
         chk("R7 flag set", 32'(bus_rdata[ch]), 32'h1);
         cmp_raw[ch] = 1'b1;
         repeat (4) @(negedge clk);
      end
      wr(5'h0C, 32'h7);

      // R6 invert sweep
      for (int r = 0; r < 2; r++) begin
         for (int inv = 0; inv < 2; inv++) begin
            set_raw(r[0] ? 3'b111 : 3'b000);
            for (int ch = 0; ch < 3; ch++) wr(5'(ch * 4), 32'h1 | (32'(inv) << 3));
            rd(5'h0C, d);
            chk("R6 output is raw xor invert", 32'(d[5:3]), (r[0] ^ inv[0]) ? 32'h7 : 32'h0);
         end
      end
      for (int ch = 0; ch < 3; ch++) wr(5'(ch * 4), 32'h1);
      wr(5'h0C, 32'h7);
      rawv = 3'b000;
      set_raw(rawv);
      wr(5'h0C, 32'h7);

      // R8 R11 write-1-to-clear sweep
      for (int m = 0; m < 8; m++) begin
         rawv = ~rawv;
         set_raw(rawv);
         wr(5'h0C, 32'(m) | 32'h38);
         rd(5'h0C, d);
         chk("R8 w1c flags", 32'(d[2:0]), 32'(~m & 7));
         chk("R11 outputs not writable", 32'(d[5:3]), 32'(rawv));
      end

      // R10 interrupt over all flag and enable combinations
      for (int fm = 0; fm < 8; fm++) begin
         wr(5'h0C, 32'h7);
         rawv = ~rawv;
         set_raw(rawv);
         wr(5'h0C, 32'(~fm & 7));
         for (int ie = 0; ie < 8; ie++) begin
            for (int ch = 0; ch < 3; ch++) wr(5'(ch * 4), 32'h1 | (32'((ie >> ch) & 1) << 1));
            #1;
            chk("R10 irq", 32'(irq), ((fm & ie) != 0) ? 32'h1 : 32'h0);
         end
         rd(5'h0C, d);
         chk("R10 flags kept regardless of enable", 32'(d[2:0]), 32'(fm));
      end
      for (int ch = 0; ch < 3; ch++) wr(5'(ch * 4), 32'h1);

      // R9 set and clear in the same cycle, with flag previously set and clear
      for (int pre = 0; pre < 2; pre++) begin
         wr(5'h0C, 32'h7);
         if (pre == 1) begin
            rawv[0] = ~rawv[0];
            set_raw(rawv);
         end
         @(negedge clk);
         rawv[0] = ~rawv[0];
         cmp_raw = rawv;
         @(negedge clk);
         @(negedge clk);
         bus_addr = 5'h0C; bus_we = 1'b1; bus_wdata = 32'h1;
         @(negedge clk);
         bus_we = 1'b0; bus_wdata = '0;
         #1 chk("R9 set wins over clear", 32'(bus_rdata[0]), 32'h1);
      end

      // R7 R5 disabled comparator neither reports nor flags
      wr(5'h0, 32'h0);
      wr(5'h0C, 32'h7);
      rawv[0] = ~rawv[0];
      set_raw(rawv);
      rawv[0] = ~rawv[0];
      set_raw(rawv);
      rd(5'h0C, d);
      chk("R7 no flag while disabled", 32'(d[0]), 32'h0);
      chk("R5 disabled output 0", 32'(d[3]), 32'h0);
      stat_out = d[5:3];
      chk("R6 enabled outputs unaffected", 32'(stat_out[2:1]), 32'(rawv[2:1]));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule